// File: doc/BRIEF.md
# Caller-Correlated Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Its history is a table of 3-bit saturating counters. The table index joins a few bits of the branch's own address with a few bits of the address of the procedure call that is currently active. As a result, one branch reached from different call sites keeps a separate history for each site.

A small hardware stack tracks the active call site. The decode stage reports each instruction's class and address. A call (jal or jalr) pushes bits [5:2] of its own address. A return (jr r31) pops the stack.

The fetch side presents a lookup PC and receives the prediction together with the table index that produced it. When the branch resolves, the pipeline sends that index and the real outcome back on the update port. Index aliasing between branches only lowers accuracy and never affects correct execution.

Top module: `caller_bht`

## Requirements
- R1: `lk_idx_o` is 12 bits: bits [11:8] are the caller field and bits [7:0] are `lk_pc_i[9:2]`. Bits [1:0] of the lookup PC have no effect on the index.
- R2: A decode with `dec_valid_i`=1 and `dec_class_i`=2'b01 (call) pushes `dec_pc_i[5:2]`. That value is the caller field from the next cycle on.
- R3: A decode with `dec_valid_i`=1 and `dec_class_i`=2'b10 (return) pops the stack. From the next cycle the caller field shows the next most recent entry.
- R4: `stk_empty_o` is 1 exactly when the stack holds no entries, including after reset. While the stack is empty the caller field is 4'b0000. A return on an empty stack leaves the stack empty.
- R5: The stack holds 8 entries. A call to a full stack discards the oldest entry, and `stk_ovf_o` is high for exactly the one cycle after that call.
- R6: After reset every counter is 0, so every lookup predicts not taken.
- R7: An update with `upd_taken_i`=1 increments the counter at `upd_idx_i`, saturating at 7. An update with 0 decrements it, saturating at 0.
- R8: `pred_taken_o` is 1 when the counter at the looked-up index is 5 or more, and 0 when it is 4 or less.
- R9: When a lookup and an update use the same index in the same cycle, the lookup returns the value from before the update. The new value is seen from the next cycle.
- R10: One branch PC looked up under different caller fields reads independent counters.
- R11: A decode with `dec_valid_i`=0, or with class 2'b00 or 2'b11, leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode slot holds a valid instruction |
| dec_class_i | input | 2 | 00 other, 01 call, 10 return, 11 other |
| dec_pc_i | input | 32 | Address of the instruction in decode |
| lk_pc_i | input | 32 | Branch address to predict |
| lk_idx_o | output | 12 | Table index used for this lookup |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Apply an outcome this cycle |
| upd_idx_i | input | 12 | Index of the counter to train |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| stk_empty_o | output | 1 | Call stack holds no entries |
| stk_ovf_o | output | 1 | One-cycle pulse after a call to a full stack |

## Verification
The hardest state to reach is the wrap of the call stack. Nine calls must arrive back to back before the overflow pulse appears. Showing that the oldest entry was really dropped also takes eight returns, with the caller field read after each one, so the bench performs that full sequence. The same-cycle read/write conflict on one counter is the other narrow case. The bench first trains an entry to the threshold minus one, then drives the update and a lookup of the same index in one cycle, checking before and after the edge.

// File: rtl/caller_bht_pkg.sv
package caller_bht_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_CALL  = 2'b01,
    CLS_RET   = 2'b10,
    CLS_RSVD  = 2'b11
  } dec_class_e;
endpackage

// File: rtl/caller_stack.sv
module caller_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] top_q, top_inc, top_dec;
  logic [CNT_W-1:0] cnt_q;
  logic             full, ovf_q;

  assign full    = (cnt_q == FULL_CNT);
  assign top_inc = (top_q == LAST_PTR) ? '0 : top_q + 1'b1;
  assign top_dec = (top_q == '0) ? LAST_PTR : top_q - 1'b1;

  // circular storage: a push to a full stack overwrites the oldest slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      ovf_q <= push_i && full;
      if (push_i) begin
        top_q        <= top_inc;
        mem_q[top_inc] <= push_val_i;
        if (!full) cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && cnt_q != '0) begin
        top_q <= top_dec;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '0 : mem_q[top_q];
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/ctr_table.sv
module ctr_table #(
  parameter int IDX_W     = 12,
  parameter int CNT_W     = 3,
  parameter int TAKEN_MIN = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(TAKEN_MIN);

  logic [CNT_W-1:0] ctr_q [ENTRIES];
  logic [CNT_W-1:0] cur, nxt;

  assign cur = ctr_q[wr_idx_i];

  always_comb begin
    nxt = cur;
    if (wr_taken_i) begin
      if (cur != CNT_MAX) nxt = cur + 1'b1;
    end else begin
      if (cur != '0) nxt = cur - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= '0;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= nxt;
    end
  end

  // read is combinational off the stored array: a same-cycle write is not seen
  assign rd_taken_o = (ctr_q[rd_idx_i] >= CNT_THR);
endmodule

// File: rtl/caller_bht.sv
module caller_bht
  import caller_bht_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CALL_W    = 4,
  parameter int BR_W      = 8,
  parameter int STK_DEPTH = 8,
  parameter int CNT_W     = 3,
  parameter int TAKEN_MIN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [1:0]        dec_class_i,
  input  logic [PC_W-1:0]   dec_pc_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  output logic [CALL_W+BR_W-1:0] lk_idx_o,
  output logic              pred_taken_o,
  input  logic              upd_valid_i,
  input  logic [CALL_W+BR_W-1:0] upd_idx_i,
  input  logic              upd_taken_i,
  output logic              stk_empty_o,
  output logic              stk_ovf_o
);
  localparam int IDX_W = CALL_W + BR_W;
  localparam int LSB   = 2;  // word-aligned instructions

  logic              is_call, is_ret;
  logic [CALL_W-1:0] caller;

  assign is_call = dec_valid_i && (dec_class_i == CLS_CALL);
  assign is_ret  = dec_valid_i && (dec_class_i == CLS_RET);

  caller_stack #(
    .DEPTH (STK_DEPTH),
    .W     (CALL_W)
  ) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (is_call),
    .pop_i      (is_ret),
    .push_val_i (dec_pc_i[LSB+CALL_W-1:LSB]),
    .top_o      (caller),
    .empty_o    (stk_empty_o),
    .ovf_o      (stk_ovf_o)
  );

  assign lk_idx_o = {caller, lk_pc_i[LSB+BR_W-1:LSB]};

  ctr_table #(
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W),
    .TAKEN_MIN (TAKEN_MIN)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx_o),
    .rd_taken_o (pred_taken_o),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx_i),
    .wr_taken_i (upd_taken_i)
  );
endmodule

// File: rtl/caller_bht_chk.sv
module caller_bht_chk
  import caller_bht_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int CALL_W = 4,
  parameter int BR_W   = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   dec_valid_i,
  input logic [1:0]             dec_class_i,
  input logic [PC_W-1:0]        dec_pc_i,
  input logic [CALL_W+BR_W-1:0] lk_idx_o,
  input logic                   stk_empty_o,
  input logic                   stk_ovf_o
);
  logic call_d, ret_d;
  assign call_d = dec_valid_i && (dec_class_i == CLS_CALL);
  assign ret_d  = dec_valid_i && (dec_class_i == CLS_RET);

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_d |=> lk_idx_o[CALL_W+BR_W-1:BR_W] == $past(dec_pc_i[CALL_W+1:2])); // R2
  AST_PUSH_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_d |=> !stk_empty_o); // R4
  AST_EMPTY_CALLER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_empty_o |-> lk_idx_o[CALL_W+BR_W-1:BR_W] == '0); // R4
  AST_POP_EMPTY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_empty_o && ret_d) |=> stk_empty_o); // R4
  AST_OVF_AFTER_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_ovf_o |-> $past(call_d) && !stk_empty_o); // R5
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_ovf_o && !call_d |=> !stk_ovf_o); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(call_d || ret_d) |=> $stable(stk_empty_o) && $stable(lk_idx_o[CALL_W+BR_W-1:BR_W])); // R11
endmodule

bind caller_bht caller_bht_chk #(
  .PC_W   (PC_W),
  .CALL_W (CALL_W),
  .BR_W   (BR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_valid_i (dec_valid_i),
  .dec_class_i (dec_class_i),
  .dec_pc_i    (dec_pc_i),
  .lk_idx_o    (lk_idx_o),
  .stk_empty_o (stk_empty_o),
  .stk_ovf_o   (stk_ovf_o)
);

// File: tb/caller_bht_test.sv
`timescale 1ns/1ps
module caller_bht_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_class = 2'b00;
  logic [31:0] dec_pc = '0;
  logic [31:0] lk_pc = '0;
  logic [11:0] lk_idx;
  logic        pred;
  logic        upd_valid = 1'b0;
  logic [11:0] upd_idx = '0;
  logic        upd_taken = 1'b0;
  logic        empty, ovf;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  caller_bht uut (
    .clk_i (clk), .rst_ni (rst_n),
    .dec_valid_i (dec_valid), .dec_class_i (dec_class), .dec_pc_i (dec_pc),
    .lk_pc_i (lk_pc), .lk_idx_o (lk_idx), .pred_taken_o (pred),
    .upd_valid_i (upd_valid), .upd_idx_i (upd_idx), .upd_taken_i (upd_taken),
    .stk_empty_o (empty), .stk_ovf_o (ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic dec_op(input logic v, input logic [1:0] cls, input logic [31:0] pc);
    dec_valid = v; dec_class = cls; dec_pc = pc;
    tick();
    dec_valid = 1'b0; dec_class = 2'b00;
  endtask

  task automatic upd(input logic [11:0] idx, input logic t);
    upd_valid = 1'b1; upd_idx = idx; upd_taken = t;
    tick();
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    lk_pc = 32'h0000_0014;
    #1;
    check("R4 empty after reset", 32'(empty), 1);
    check("R5 no ovf after reset", 32'(ovf), 0);
    check("R4 caller zero after reset", 32'(lk_idx[11:8]), 0);
    check("R6 reset predicts NT", 32'(pred), 0);
  endtask

  task automatic t_index;
    lk_pc = 32'hABCD_E3F7; #1;
    check("R1 index from pc[9:2]", 32'(lk_idx), 32'h0FD);
    lk_pc = 32'hABCD_E3F4; #1;
    check("R1 low bits ignored", 32'(lk_idx), 32'h0FD);
  endtask

  task automatic t_stack;
    dec_op(1'b1, 2'b01, 32'h0000_0034);
    check("R2 push top", 32'(lk_idx[11:8]), 32'hD);
    check("R4 not empty after push", 32'(empty), 0);
    dec_op(1'b1, 2'b01, 32'h0000_0018);
    check("R2 second push top", 32'(lk_idx[11:8]), 32'h6);
    dec_op(1'b0, 2'b01, 32'h0000_003C);
    check("R11 invalid call ignored", 32'(lk_idx[11:8]), 32'h6);
    dec_op(1'b1, 2'b00, 32'h0000_003C);
    check("R11 class other ignored", 32'(lk_idx[11:8]), 32'h6);
    dec_op(1'b1, 2'b11, 32'h0000_003C);
    check("R11 class 11 ignored", 32'(lk_idx[11:8]), 32'h6);
    dec_op(1'b1, 2'b10, 32'h0);
    check("R3 pop reveals older", 32'(lk_idx[11:8]), 32'hD);
    dec_op(1'b1, 2'b10, 32'h0);
    check("R4 empty after last pop", 32'(empty), 1);
    check("R4 caller zero when empty", 32'(lk_idx[11:8]), 0);
    dec_op(1'b1, 2'b10, 32'h0);
    check("R4 pop on empty stays empty", 32'(empty), 1);
    dec_op(1'b1, 2'b01, 32'h0000_0008);
    check("R4 push after empty pop", 32'(lk_idx[11:8]), 32'h2);
    dec_op(1'b1, 2'b10, 32'h0);
  endtask

  task automatic t_overflow;
    for (int i = 1; i <= 9; i++) begin
      dec_op(1'b1, 2'b01, 32'(i * 4));
      check(i == 9 ? "R5 ovf pulse on full push" : "R5 no ovf before full", 32'(ovf), (i == 9) ? 1 : 0);
    end
    tick();
    check("R5 ovf lasts one cycle", 32'(ovf), 0);
    check("R5 top after wrap", 32'(lk_idx[11:8]), 9);
    for (int k = 1; k <= 8; k++) begin
      dec_op(1'b1, 2'b10, 32'h0);
      if (k < 8) check("R5 pop order after wrap", 32'(lk_idx[11:8]), 32'(9 - k));
      else check("R5 oldest discarded, empty after 8 pops", 32'(empty), 1);
    end
  endtask

  task automatic t_counters;
    lk_pc = 32'h0000_0014; #1;
    for (int i = 0; i < 4; i++) upd(12'h005, 1'b1);
    check("R8 count 4 predicts NT", 32'(pred), 0);
    upd(12'h005, 1'b1);
    check("R8 count 5 predicts T", 32'(pred), 1);
    for (int i = 0; i < 5; i++) upd(12'h005, 1'b1);
    for (int i = 0; i < 2; i++) upd(12'h005, 1'b0);
    check("R7 saturated at 7, two NT keep T", 32'(pred), 1);
    upd(12'h005, 1'b0);
    check("R7 third NT from 7 gives NT", 32'(pred), 0);
    for (int i = 0; i < 10; i++) upd(12'h005, 1'b0);
    for (int i = 0; i < 4; i++) upd(12'h005, 1'b1);
    check("R7 saturated at 0, four T still NT", 32'(pred), 0);
    upd(12'h005, 1'b1);
    check("R7 fifth T from 0 gives T", 32'(pred), 1);
  endtask

  task automatic t_bypass;
    lk_pc = 32'h0000_0080; #1;
    check("R9 fresh entry NT", 32'(pred), 0);
    for (int i = 0; i < 4; i++) upd(12'h020, 1'b1);
    upd_valid = 1'b1; upd_idx = 12'h020; upd_taken = 1'b1;
    #1;
    check("R9 same-cycle lookup sees old value", 32'(pred), 0);
    tick();
    upd_valid = 1'b0;
    check("R9 update visible next cycle", 32'(pred), 1);
  endtask

  task automatic t_separate;
    dec_op(1'b1, 2'b01, 32'h0000_003C);
    lk_pc = 32'h0000_0014; #1;
    check("R10 index with caller F", 32'(lk_idx), 32'hF05);
    check("R10 other caller has own history", 32'(pred), 0);
    dec_op(1'b1, 2'b10, 32'h0);
    check("R10 caller 0 history kept", 32'(pred), 1);
  endtask

  initial begin
    #20;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_index();
    t_stack();
    t_overflow();
    t_counters();
    t_bypass();
    t_separate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule